// File: doc/BRIEF.md
# Non-Maskable and Top-Level Interrupt Entry Controller

This block handles exception entry for a small processor core. It serves two request lines: a non-maskable interrupt and the highest-priority maskable interrupt level. While idle, it compares both level-sensitive request lines with the current status register. When it accepts a request, it asks the pipeline to drain and waits for the drain to finish. In a single commit cycle it then does all of the following:

- saves the old status word and the resume address into that exception's own shadow pair;
- rewrites the mode and mask fields of the status word;
- emits the handler address together with a one-cycle redirect strobe.

The non-maskable handler lives at a fixed offset from the vector base. The level-3 handler lives at the vector base plus an offset that an external interrupt controller supplies. The rest of the core can load the status word through a write port, which stands in for handler return and explicit status updates.

The status word is 11 bits wide:

| Bits | Field |
|------|-------|
| [10:8] | mode |
| [7] | exception mask EM |
| [6] | global mask GM |
| [5:2] | level masks, where bit 5 masks level 3 and bit 2 masks level 0 |
| [1] | R flag |
| [0] | J flag |

Top module: `exc_entry_ctrl`

## Requirements
- R1: After synchronous reset, the status word reads 0x140 (mode 3'b001, GM set, every other bit clear). Both shadow pairs, `new_pc`, `drain_req` and `redirect` read zero.
- R2: While idle, a high `nmi_req` is accepted whatever the masks hold, unless mode equals 3'b111. In that mode the line is ignored.
- R3: While idle, a high `int3_req` is accepted only when GM (bit 6) and the level-3 mask (bit 5) are both clear.
- R4: When both requests are acceptable in the same cycle, the non-maskable one is taken. A level-3 request that is still asserted afterwards is checked against the updated status word, which blocks it.
- R5: `drain_req` is high from the cycle after acceptance until the cycle after `drain_done` is seen high. The commit occurs in the next cycle. `redirect` pulses for exactly one cycle after the commit, and the new status word, `new_pc` and the shadow values are visible in that same cycle.
- R6: At commit, the pre-entry status word and the `first_nc_addr` value present in the commit cycle are stored in the shadow pair of the exception taken. The other pair is left unchanged.
- R7: Non-maskable entry sets the following fields and leaves the other bits as they were:
  - mode = 3'b111
  - EM and GM set
  - R and J cleared
  - `new_pc` = `vec_base` + NMI_OFS (default 0x10)
- R8: Level-3 entry sets the following fields and leaves the other bits (GM and EM included) as they were:
  - mode = 3'b101
  - all four level masks set
  - R and J cleared
  - `new_pc` = `vec_base` + `int3_offset`
- R9: A request that is accepted and then dropped during the drain still commits.
- R10: `sr_wr_en` loads `sr_wr_data` into the status word only while idle, and no request is sampled in that cycle. Outside idle the write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_req | input | 1 | Non-maskable request level |
| int3_req | input | 1 | Level-3 request level |
| sr_wr_en | input | 1 | Status word load enable |
| sr_wr_data | input | 11 | Status word load value |
| drain_done | input | 1 | Pipeline has drained |
| first_nc_addr | input | AW | Address of first non-completed instruction |
| vec_base | input | AW | Exception vector base |
| int3_offset | input | AW | Level-3 handler offset from the interrupt controller |
| drain_req | output | 1 | Request to drain the pipeline |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| new_pc | output | AW | Handler address |
| status | output | 11 | Current status word |
| nmi_saved_sr | output | 11 | Non-maskable shadow status |
| nmi_saved_ra | output | AW | Non-maskable shadow return address |
| int3_saved_sr | output | 11 | Level-3 shadow status |
| int3_saved_ra | output | AW | Level-3 shadow return address |

## Verification
The bench tries all 128 combinations of the eight mode encodings, GM, the level-3 mask and the two request lines. This separates mode-only blocking of the non-maskable line from mask-based gating of level 3, and also separates the priority case from each single request. Filler bits vary from case to case, so a field update that disturbs its neighbours or takes a stale value is detected. On every accepted entry, the bench re-raises the level-3 line to confirm the new masks block it. On alternate cases it writes to the status word during the drain to confirm the write is ignored. A directed case combines a status write with a request to show that sampling is suppressed.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int NLVL = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_COMMIT} st_e;
    typedef enum logic {SRC_NMI = 1'b0, SRC_INT3 = 1'b1} src_e;

    typedef struct packed {
        logic [2:0]      mode;
        logic            em;
        logic            gm;
        logic [NLVL-1:0] lvl_mask;
        logic            r;
        logic            j;
    } sr_t;

    localparam int SR_W = $bits(sr_t);
    localparam int LVL_TOP = NLVL - 1;
    localparam logic [2:0] MODE_SUP  = 3'b001;
    localparam logic [2:0] MODE_INT3 = 3'b101;
    localparam logic [2:0] MODE_NMI  = 3'b111;
endpackage

// File: rtl/exc_accept.sv
module exc_accept
    import exc_entry_pkg::*;
(
    input  sr_t  cur_sr,
    input  logic sample_en,
    input  logic nmi_req,
    input  logic int3_req,
    output logic take,
    output src_e take_src
);
    logic nmi_ok;
    logic int3_ok;

    always_comb begin
        nmi_ok   = nmi_req && (cur_sr.mode != MODE_NMI);
        int3_ok  = int3_req && !cur_sr.gm && !cur_sr.lvl_mask[LVL_TOP];
        take     = sample_en && (nmi_ok || int3_ok);
        take_src = nmi_ok ? SRC_NMI : SRC_INT3;
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] NMI_OFS = 'h10
) (
    input  src_e          src,
    input  sr_t           cur_sr,
    input  logic [AW-1:0] vec_base,
    input  logic [AW-1:0] int3_offset,
    output sr_t           nxt_sr,
    output logic [AW-1:0] tgt_pc
);
    always_comb begin
        nxt_sr   = cur_sr;
        nxt_sr.r = 1'b0;
        nxt_sr.j = 1'b0;
        if (src == SRC_NMI) begin
            nxt_sr.mode = MODE_NMI;
            nxt_sr.em   = 1'b1;
            nxt_sr.gm   = 1'b1;
            tgt_pc      = vec_base + NMI_OFS;
        end else begin
            nxt_sr.mode = MODE_INT3;
            for (int k = 0; k < NLVL; k++) begin
                nxt_sr.lvl_mask[k] = 1'b1;
            end
            tgt_pc = vec_base + int3_offset;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] NMI_OFS = 'h10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            nmi_req,
    input  logic            int3_req,
    input  logic            sr_wr_en,
    input  logic [SR_W-1:0] sr_wr_data,
    input  logic            drain_done,
    input  logic [AW-1:0]   first_nc_addr,
    input  logic [AW-1:0]   vec_base,
    input  logic [AW-1:0]   int3_offset,
    output logic            drain_req,
    output logic            redirect,
    output logic [AW-1:0]   new_pc,
    output logic [SR_W-1:0] status,
    output logic [SR_W-1:0] nmi_saved_sr,
    output logic [AW-1:0]   nmi_saved_ra,
    output logic [SR_W-1:0] int3_saved_sr,
    output logic [AW-1:0]   int3_saved_ra
);
    localparam int NSRC = 2;

    typedef struct packed {
        st_e                       st;
        src_e                      src;
        sr_t                       sr;
        logic [AW-1:0]             pc;
        logic                      redir;
        logic [NSRC-1:0][SR_W-1:0] sav_sr;
        logic [NSRC-1:0][AW-1:0]   sav_ra;
    } regs_t;

    regs_t r_d, r_q;

    logic  take;
    src_e  take_src;
    sr_t   tgt_sr;
    logic [AW-1:0] tgt_pc;

    exc_accept u_accept (
        .cur_sr    (r_q.sr),
        .sample_en ((r_q.st == ST_IDLE) && !sr_wr_en),
        .nmi_req   (nmi_req),
        .int3_req  (int3_req),
        .take      (take),
        .take_src  (take_src)
    );

    exc_target #(.AW(AW), .NMI_OFS(NMI_OFS)) u_target (
        .src         (r_q.src),
        .cur_sr      (r_q.sr),
        .vec_base    (vec_base),
        .int3_offset (int3_offset),
        .nxt_sr      (tgt_sr),
        .tgt_pc      (tgt_pc)
    );

    always_comb begin
        r_d       = r_q;
        r_d.redir = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (sr_wr_en) begin
                    r_d.sr = sr_t'(sr_wr_data);
                end else if (take) begin
                    r_d.st  = ST_DRAIN;
                    r_d.src = take_src;
                end
            end
            ST_DRAIN: begin
                if (drain_done) begin
                    r_d.st = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                r_d.sav_sr[r_q.src] = r_q.sr;
                r_d.sav_ra[r_q.src] = first_nc_addr;
                r_d.sr    = tgt_sr;
                r_d.pc    = tgt_pc;
                r_d.redir = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.src     <= SRC_NMI;
            r_q.sr.mode <= MODE_SUP;
            r_q.sr.gm   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign drain_req     = (r_q.st == ST_DRAIN);
    assign redirect      = r_q.redir;
    assign new_pc        = r_q.pc;
    assign status        = r_q.sr;
    assign nmi_saved_sr  = r_q.sav_sr[SRC_NMI];
    assign nmi_saved_ra  = r_q.sav_ra[SRC_NMI];
    assign int3_saved_sr = r_q.sav_sr[SRC_INT3];
    assign int3_saved_ra = r_q.sav_ra[SRC_INT3];
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            nmi_req,
    input logic            int3_req,
    input logic            sr_wr_en,
    input logic            drain_done,
    input logic            drain_req,
    input logic            redirect,
    input logic [SR_W-1:0] status
);
    sr_t sr;
    assign sr = sr_t'(status);

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !redirect); // R5

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (drain_req && !drain_done) |=> drain_req); // R9

    AST_REDIRECT_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (!$past(drain_req) && $past(drain_req, 2))); // R5

    AST_ACCEPT_RULE: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_req) |-> $past(!sr_wr_en &&
            ((nmi_req && sr.mode != MODE_NMI) ||
             (int3_req && !sr.gm && !sr.lvl_mask[LVL_TOP])))); // R2 R3

    AST_NMI_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (redirect && sr.mode == MODE_NMI) |-> (sr.gm && sr.em && !sr.r && !sr.j)); // R7

    AST_INT3_MASKS: assert property (@(posedge clk) disable iff (rst)
        (redirect && sr.mode == MODE_INT3) |-> (sr.lvl_mask == '1 && !sr.r && !sr.j)); // R8

    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!redirect && !$past(sr_wr_en)) |-> $stable(status)); // R10
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .nmi_req    (nmi_req),
    .int3_req   (int3_req),
    .sr_wr_en   (sr_wr_en),
    .drain_done (drain_done),
    .drain_req  (drain_req),
    .redirect   (redirect),
    .status     (status)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    localparam int AW = 32;
    localparam int SW = 11;

    logic clk = 1'b0;
    logic rst;
    logic nmi_req, int3_req, sr_wr_en, drain_done;
    logic [SW-1:0] sr_wr_data;
    logic [AW-1:0] first_nc_addr, vec_base, int3_offset;
    logic drain_req, redirect;
    logic [AW-1:0] new_pc, nmi_saved_ra, int3_saved_ra;
    logic [SW-1:0] status, nmi_saved_sr, int3_saved_sr;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    exc_entry_ctrl #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .int3_req(int3_req),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .drain_done(drain_done),
        .first_nc_addr(first_nc_addr), .vec_base(vec_base), .int3_offset(int3_offset),
        .drain_req(drain_req), .redirect(redirect), .new_pc(new_pc), .status(status),
        .nmi_saved_sr(nmi_saved_sr), .nmi_saved_ra(nmi_saved_ra),
        .int3_saved_sr(int3_saved_sr), .int3_saved_ra(int3_saved_ra)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [SW-1:0] e_nsr, e_isr, e_sr;
    logic [AW-1:0] e_nra, e_ira, e_pc;

    task automatic check_shadows(input string req);
        check(req, "nmi_saved_sr", nmi_saved_sr, e_nsr);
        check(req, "nmi_saved_ra", nmi_saved_ra, e_nra);
        check(req, "int3_saved_sr", int3_saved_sr, e_isr);
        check(req, "int3_saved_ra", int3_saved_ra, e_ira);
    endtask

    initial begin
        rst = 1'b1; nmi_req = 0; int3_req = 0; sr_wr_en = 0; drain_done = 0;
        sr_wr_data = '0; first_nc_addr = '0; vec_base = '0; int3_offset = '0;
        @(negedge clk);
        tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        e_sr = 11'h140; e_nsr = '0; e_isr = '0; e_nra = '0; e_ira = '0; e_pc = '0;
        check("R1", "status", status, e_sr);
        check("R1", "drain_req", drain_req, 0);
        check("R1", "redirect", redirect, 0);
        check("R1", "new_pc", new_pc, 0);
        check_shadows("R1");

        // R10: a write in the same cycle as a request suppresses sampling
        sr_wr_en = 1; sr_wr_data = 11'h100; nmi_req = 1;
        tick();
        sr_wr_en = 0; nmi_req = 0;
        check("R10", "drain_req with write", drain_req, 0);
        check("R10", "status loaded", status, 11'h100);
        tick();
        check("R10", "drain_req after", drain_req, 0);

        for (int c = 0; c < 128; c++) begin
            logic [2:0] mode;
            logic gm, i3m, nreq, ireq, n_ok, i_ok, acc, is_nmi;
            logic [SW-1:0] pat;
            logic [AW-1:0] fnc;
            mode = c[2:0]; gm = c[3]; i3m = c[4]; nreq = c[5]; ireq = c[6];
            pat = {mode, c[0] ^ c[3], gm, i3m, c[2:0] ^ 3'b101, c[1], c[0] ^ c[6]};
            fnc = 32'h1000 + c * 4;
            n_ok = nreq && (mode != 3'b111);
            i_ok = ireq && !gm && !i3m;
            acc = n_ok || i_ok;
            is_nmi = n_ok;

            sr_wr_en = 1; sr_wr_data = pat;
            tick();
            sr_wr_en = 0; nmi_req = nreq; int3_req = ireq;
            tick();
            nmi_req = 0; int3_req = 0;
            // R2 R3 R4 acceptance
            check(is_nmi ? "R2" : "R3", "drain_req after sample", drain_req, acc);
            if (!acc) begin
                check("R10", "status unchanged", status, pat);
                check_shadows("R6");
                continue;
            end
            // R9: requests dropped; R10: write during drain ignored on odd cases
            if (c[0]) begin sr_wr_en = 1; sr_wr_data = ~pat; end
            tick();
            sr_wr_en = 0;
            check("R9", "drain_req held", drain_req, 1);
            check("R10", "status during drain", status, pat);
            drain_done = 1; first_nc_addr = fnc;
            vec_base = 32'h8000_0000 + c * 256; int3_offset = c * 8 + 4;
            tick();
            drain_done = 0;
            check("R5", "drain_req in commit", drain_req, 0);
            check("R5", "redirect in commit", redirect, 0);
            tick();
            e_sr = pat;
            e_sr[1:0] = 2'b00;
            if (is_nmi) begin
                e_sr[10:8] = 3'b111; e_sr[7] = 1; e_sr[6] = 1;
                e_pc = vec_base + 32'h10;
                e_nsr = pat; e_nra = fnc;
            end else begin
                e_sr[10:8] = 3'b101; e_sr[5:2] = 4'hF;
                e_pc = vec_base + int3_offset;
                e_isr = pat; e_ira = fnc;
            end
            check("R5", "redirect strobe", redirect, 1);
            check(is_nmi ? "R7" : "R8", "status after entry", status, e_sr);
            check(is_nmi ? "R7" : "R8", "new_pc", new_pc, e_pc);
            check_shadows("R6");
            // R4: re-raised level-3 request is now blocked
            int3_req = 1;
            tick();
            check("R5", "redirect single cycle", redirect, 0);
            check("R4", "int3 blocked after entry", drain_req, 0);
            int3_req = 0;
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule